// File: doc/BRIEF.md
# General-Purpose I/O Port with Timer Channel Takeover

This block is a seven-pin bidirectional I/O port. Software reaches two byte-wide registers over a small register bus with an address, a read strobe and a write strobe. The data register holds the value each pin drives when it is an output. The direction register selects, for each pin, whether its driver is on. The block drives a per-pin output enable and output value toward the pads. It takes raw pin levels and passes them through a two-flop synchronizer before any other logic sees them.

Four pins can be handed to timer capture/compare channels. Each channel has a two-bit mode select. Any nonzero select gives the pin to its timer. The timer's output enable and output value then drive the pad, and the direction register has no effect on that pin. A data register read still uses the direction bit to pick the source of each bit. A direction bit of 1 returns the latch and a direction bit of 0 returns the synchronized pin. This holds whether or not a timer owns the pin. The synchronized levels of the four shared pins are also sent to the timers as capture inputs.

The data latch has no reset, so its contents survive a reset. Software can load the latch while a pin is still an input, then enable the driver. The pad then drives the new value from its first driven cycle.

Top module: `gpio_timer_port`

## Requirements
- R1: Bit 7 of both registers always reads as 0. Writing 1 to bit 7 changes nothing.
- R2: The data register sits at bus offset 1 and the direction register at offset 5. A write takes effect at the clock edge where the write strobe is sampled. The pad outputs show the new state one clock edge after that.
- R3: Reset clears every direction bit. One edge after reset is sampled, `pad_oe` is all zero and the pad output register is cleared.
- R4: Reset leaves the data latch unchanged. After reset, setting the direction bits to 1 shows the old latch contents on a read and on `pad_out`.
- R5: A read of the data register returns, for each pin, the latch bit when its direction bit is 1 and the synchronized pin level when it is 0. This applies to timer-owned pins too. Read data appears on `bus_rdata` one edge after the read strobe is sampled. It is 0 in any cycle without a read.
- R6: For a pin no timer owns, `pad_oe` follows its direction bit and `pad_out` follows its latch bit.
- R7: The timer channel order in `tmr_sel`, `tmr_oe`, `tmr_out` and `tmr_cap_in` is 0: pin 0, 1: pin 1, 2: pin 4, 3: pin 5. Channel k's select is `tmr_sel[2k+1:2k]`. When that select is nonzero, the pin's `pad_oe` and `pad_out` follow `tmr_oe[k]` and `tmr_out[k]` and ignore its direction bit. When the select is zero, the pin is an ordinary port pin.
- R8: If the latch is written and then the direction bit goes from 0 to 1, the first cycle with `pad_oe` set already carries the new latch value on `pad_out`.
- R9: A read of the direction register returns its seven bits with bit 7 zero. An access at any other offset reads 0.
- R10: `pin_in` passes through two flops. `tmr_cap_in` and the data read path see a pin change two edges after it is sampled, and not one edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 7 | Raw pin levels |
| pad_oe | output | 7 | Per-pin driver enable |
| pad_out | output | 7 | Per-pin drive value |
| tmr_sel | input | 8 | Two-bit mode select per timer channel |
| tmr_oe | input | 4 | Timer output enable per channel |
| tmr_out | input | 4 | Timer output value per channel |
| tmr_cap_in | output | 4 | Synchronized pin level per channel |

## Verification
Some properties are checked on every cycle:
- the reserved bit reading zero;
- cleared drivers after reset;
- pad outputs of ordinary pins tracking the direction and latch registers one cycle later;
- timer-owned pins tracking the timer signals;
- the two-cycle synchronizer delay;
- the direction register read value.

Other behaviour needs the bench's scenarios:
- the latch surviving reset, which spans a reset and a later reconfiguration;
- the per-bit choice between latch and pin on a data read, including owned pins;
- the glitch-free enable ordering;
- the full sweeps over direction values and all 256 timer select combinations.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int NUM_TCH = 4;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_DIR  = 2'd2
  } rsel_e;

  // Which timer channel may own a given pin; -1 when none.
  function automatic int pin_chan(input int pin);
    case (pin)
      0:       return 0;
      1:       return 1;
      4:       return 2;
      5:       return 3;
      default: return -1;
    endcase
  endfunction

  // Pin served by a given timer channel.
  function automatic int chan_pin(input int ch);
    case (ch)
      0:       return 0;
      1:       return 1;
      2:       return 4;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_W    = 7,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int DATA_OFS = 1,
  parameter int DIR_OFS  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PIN_W-1:0]  pin_sync,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  latch_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - PIN_W;

  rsel_e            rsel;
  logic [PIN_W-1:0] rd_bits;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:PIN_W];

  always_comb begin
    if (addr == ADDR_W'(DATA_OFS))     rsel = RSEL_DATA;
    else if (addr == ADDR_W'(DIR_OFS)) rsel = RSEL_DIR;
    else                               rsel = RSEL_NONE;
  end

  // Data latch: deliberately without reset.
  always_ff @(posedge clk) begin
    if (wr && rsel == RSEL_DATA) latch_q <= wdata[PIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                         dir_q <= '0;
    else if (wr && rsel == RSEL_DIR) dir_q <= wdata[PIN_W-1:0];
  end

  always_comb begin
    case (rsel)
      RSEL_DATA: rd_bits = (dir_q & latch_q) | (~dir_q & pin_sync);
      RSEL_DIR:  rd_bits = dir_q;
      default:   rd_bits = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= {{PAD_W{1'b0}}, rd_bits};
    else         rdata <= '0;
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int PIN_W  = 7,
  parameter int NUM_CH = NUM_TCH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PIN_W-1:0]    dir_q,
  input  logic [PIN_W-1:0]    latch_q,
  input  logic [2*NUM_CH-1:0] tmr_sel,
  input  logic [NUM_CH-1:0]   tmr_oe,
  input  logic [NUM_CH-1:0]   tmr_out,
  output logic [PIN_W-1:0]    pad_oe,
  output logic [PIN_W-1:0]    pad_out
);

  logic [PIN_W-1:0] oe_nxt;
  logic [PIN_W-1:0] out_nxt;

  generate
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      localparam int CH = pin_chan(p);
      if (CH >= 0 && CH < NUM_CH) begin : g_shared
        logic owned;
        assign owned      = |tmr_sel[2*CH +: 2];
        assign oe_nxt[p]  = owned ? tmr_oe[CH]  : dir_q[p];
        assign out_nxt[p] = owned ? tmr_out[CH] : latch_q[p];
      end else begin : g_plain
        assign oe_nxt[p]  = dir_q[p];
        assign out_nxt[p] = latch_q[p];
      end
    end
  endgenerate

  // Enable and value share one register stage so they change together.
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= oe_nxt;
      pad_out <= out_nxt;
    end
  end

endmodule

// File: rtl/gpio_timer_port.sv
module gpio_timer_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_W       = 7,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int DATA_OFS    = 1,
  parameter int DIR_OFS     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [PIN_W-1:0]     pin_in,
  output logic [PIN_W-1:0]     pad_oe,
  output logic [PIN_W-1:0]     pad_out,
  input  logic [2*NUM_TCH-1:0] tmr_sel,
  input  logic [NUM_TCH-1:0]   tmr_oe,
  input  logic [NUM_TCH-1:0]   tmr_out,
  output logic [NUM_TCH-1:0]   tmr_cap_in
);

  logic [PIN_W-1:0] pin_sync;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] latch_q;

  gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_regs #(
    .PIN_W(PIN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .latch_q  (latch_q),
    .rdata    (bus_rdata)
  );

  gpio_pin_mux #(.PIN_W(PIN_W), .NUM_CH(NUM_TCH)) u_mux (
    .clk     (clk),
    .rst     (rst),
    .dir_q   (dir_q),
    .latch_q (latch_q),
    .tmr_sel (tmr_sel),
    .tmr_oe  (tmr_oe),
    .tmr_out (tmr_out),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  generate
    for (genvar k = 0; k < NUM_TCH; k++) begin : g_cap
      assign tmr_cap_in[k] = pin_sync[chan_pin(k)];
    end
  endgenerate

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
  import gpio_port_pkg::*;
#(
  parameter int PIN_W   = 7,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int DIR_OFS = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_rd,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [PIN_W-1:0]     pin_in,
  input logic [PIN_W-1:0]     pad_oe,
  input logic [PIN_W-1:0]     pad_out,
  input logic [2*NUM_TCH-1:0] tmr_sel,
  input logic [NUM_TCH-1:0]   tmr_oe,
  input logic [NUM_TCH-1:0]   tmr_out,
  input logic [NUM_TCH-1:0]   tmr_cap_in,
  input logic [PIN_W-1:0]     dir_q,
  input logic [PIN_W-1:0]     latch_q
);

  logic       rst_seen;
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  // R3: drivers are off the edge after reset.
  always_ff @(posedge clk) begin
    if (rst_seen === 1'b1) begin
      assert_reset_clears_oe_R3: assert (pad_oe == '0);
    end
  end

  assert_reserved_bit_zero_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_rdata[DATA_W-1] == 1'b0));

  assert_dir_readback_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(DIR_OFS)) |=>
      (bus_rdata == {{(DATA_W-PIN_W){1'b0}}, $past(dir_q)}));

  assert_sync_delay_R10: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2) |->
      (tmr_cap_in == {$past(pin_in[5], 2), $past(pin_in[4], 2),
                      $past(pin_in[1], 2), $past(pin_in[0], 2)}));

  generate
    for (genvar p = 0; p < PIN_W; p++) begin : g_chk
      localparam int CH = pin_chan(p);
      if (CH >= 0 && CH < NUM_TCH) begin : g_owned
        assert_timer_owns_pin_R7: assert property (@(posedge clk) disable iff (rst)
          (tmr_sel[2*CH +: 2] != 2'b00) |=>
            (pad_oe[p] == $past(tmr_oe[CH]) && pad_out[p] == $past(tmr_out[CH])));
        assert_released_pin_R6: assert property (@(posedge clk) disable iff (rst)
          (tmr_sel[2*CH +: 2] == 2'b00) |=>
            (pad_oe[p] == $past(dir_q[p]) && pad_out[p] == $past(latch_q[p])));
      end else begin : g_plain
        assert_plain_pin_R6: assert property (@(posedge clk) disable iff (rst)
          (since_rst >= 1) |->
            (pad_oe[p] == $past(dir_q[p]) && pad_out[p] == $past(latch_q[p])));
      end
    end
  endgenerate

endmodule

bind gpio_timer_port gpio_port_checker #(
  .PIN_W(PIN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .pin_in     (pin_in),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .tmr_sel    (tmr_sel),
  .tmr_oe     (tmr_oe),
  .tmr_out    (tmr_out),
  .tmr_cap_in (tmr_cap_in),
  .dir_q      (dir_q),
  .latch_q    (latch_q)
);

// File: tb/gpio_timer_port_bench.sv
module gpio_timer_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_DATA = 3'd1;
  localparam logic [2:0] A_DIR  = 3'd5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] pin_in = '0;
  logic [6:0] pad_oe;
  logic [6:0] pad_out;
  logic [7:0] tmr_sel = '0;
  logic [3:0] tmr_oe = '0;
  logic [3:0] tmr_out = '0;
  logic [3:0] tmr_cap_in;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_timer_port u_gpio_timer_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .tmr_sel(tmr_sel), .tmr_oe(tmr_oe),
    .tmr_out(tmr_out), .tmr_cap_in(tmr_cap_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    check(pad_oe == 7'h00, "R3 pad_oe in reset", pad_oe, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int ch_of(input int p);
    if (p == 0) return 0;
    if (p == 1) return 1;
    if (p == 4) return 2;
    if (p == 5) return 3;
    return -1;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();

    // Reset state
    check(pad_oe == 7'h00, "R3 pad_oe after reset", pad_oe, 0);
    check(pad_out == 7'h00, "R3 pad_out after reset", pad_out, 0);
    bus_read(A_DIR, rv);
    check(rv == 8'h00, "R3 dir after reset", rv, 0);

    // Reserved bit and other offsets
    bus_write(A_DIR, 8'hFF);
    bus_read(A_DIR, rv);
    check(rv == 8'h7F, "R1 dir bit7", rv, 8'h7F);
    bus_write(A_DATA, 8'hFF);
    bus_read(A_DATA, rv);
    check(rv == 8'h7F, "R1 data bit7", rv, 8'h7F);
    bus_read(3'd3, rv);
    check(rv == 8'h00, "R9 unmapped offset", rv, 0);
    @(negedge clk);
    check(bus_rdata == 8'h00, "R5 idle rdata", bus_rdata, 0);

    // Glitch-free enable ordering
    bus_write(A_DIR, 8'h00);
    bus_write(A_DATA, 8'h00);
    settle();
    bus_write(A_DATA, 8'h5A);
    bus_write(A_DIR, 8'h7F);
    check(pad_oe == 7'h00, "R2 oe one edge after write", pad_oe, 0);
    settle();
    check(pad_oe == 7'h7F, "R8 first enabled oe", pad_oe, 8'h7F);
    check(pad_out == 7'h5A, "R8 first enabled value", pad_out, 8'h5A);

    // Latch survives reset
    pulse_reset();
    settle();
    check(pad_oe == 7'h00, "R3 oe after mid reset", pad_oe, 0);
    bus_write(A_DIR, 8'h7F);
    bus_read(A_DATA, rv);
    check(rv == 8'h5A, "R4 latch kept read", rv, 8'h5A);
    settle();
    check(pad_out == 7'h5A, "R4 latch kept pad", pad_out, 8'h5A);

    // Synchronizer delay
    @(negedge clk);
    pin_in = 7'h33;
    @(posedge clk); #1;
    check(tmr_cap_in == 4'h0, "R10 one edge", tmr_cap_in, 0);
    @(posedge clk); #1;
    check(tmr_cap_in == 4'hF, "R10 two edges", tmr_cap_in, 4'hF);

    // Direction sweep over all values, ordinary mode
    for (int d = 0; d < 128; d++) begin
      logic [6:0] lv, pv, exp;
      lv = 7'(d) ^ 7'h55;
      pv = ~7'(d) ^ 7'h0C;
      @(negedge clk);
      pin_in = pv;
      bus_write(A_DATA, {1'b0, lv});
      bus_write(A_DIR, {1'b1, 7'(d)});
      settle();
      check(pad_oe == 7'(d), "R6 sweep oe", pad_oe, d);
      check(pad_out == lv, "R6 sweep out", pad_out, lv);
      exp = (7'(d) & lv) | (~7'(d) & pv);
      bus_read(A_DATA, rv);
      check(rv == {1'b0, exp}, "R5 sweep read", rv, exp);
      bus_read(A_DIR, rv);
      check(rv == {1'b0, 7'(d)}, "R9 sweep dir", rv, d);
    end

    // Timer select sweep over all combinations
    bus_write(A_DIR, 8'h56);
    bus_write(A_DATA, 8'h19);
    for (int s = 0; s < 256; s++) begin
      logic [6:0] eoe, eout;
      @(negedge clk);
      tmr_sel = 8'(s);
      tmr_oe  = 4'(s) ^ 4'(s >> 4);
      tmr_out = ~4'(s >> 2);
      settle();
      for (int p = 0; p < 7; p++) begin
        int c;
        c = ch_of(p);
        if (c >= 0 && tmr_sel[2*c +: 2] != 2'b00) begin
          eoe[p] = tmr_oe[c];
          eout[p] = tmr_out[c];
        end else begin
          eoe[p] = (p == 1 || p == 2 || p == 4 || p == 6);
          eout[p] = ((7'h19 >> p) & 7'h1) != 0;
        end
      end
      check(pad_oe == eoe, "R7 sel sweep oe", pad_oe, eoe);
      check(pad_out == eout, "R7 sel sweep out", pad_out, eout);
    end

    // Read selection on owned pins still follows direction bits
    @(negedge clk);
    tmr_sel = 8'h55;
    pin_in = 7'h2C;
    bus_write(A_DATA, 8'h4B);
    bus_write(A_DIR, 8'h33);
    bus_read(A_DATA, rv);
    check(rv == 8'h0F, "R5 owned pins read", rv, 8'h0F);
    bus_write(A_DIR, 8'h00);
    bus_read(A_DATA, rv);
    check(rv == 8'h2C, "R5 owned pins as inputs", rv, 8'h2C);
    settle();
    check(pad_oe[2] == 1'b0 && pad_oe[0] == tmr_oe[0], "R7 dir ignored on owned",
          pad_oe, {6'b0, tmr_oe[0]});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule